// File: doc/BRIEF.md
# DDR memory initialization sequencer

This block wakes an external DDR1 or DDR2 memory after reset by issuing a fixed series of commands: precharge-all, loads of the extended and base mode registers, and auto-refresh. A single pulse on `start` launches the series. Each command appears on a command port as a one-hot control word plus a mode-register value, and it is held there until the downstream controller takes it by raising `cmd_ready`. A fixed idle gap, set by a parameter, separates each accepted command from the next one.

Two strap inputs are captured when the series begins. One chooses between the DDR1 and the DDR2 command series. The other chooses the refresh interval for a 25 MHz or a 40 MHz reference. In DDR2 mode the DDR2 configuration word is driven out before the first command is offered. The cycle after the last command is accepted, the block loads the refresh word with its enable bit set, loads both DQS tap outputs with their defaults, and raises `init_done`, which stays high until reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge and afterwards until `start`, `cmd_valid`, `init_done`, `ddr2_cfg`, `refresh_word`, `dqs_tap0` and `dqs_tap1` are all zero. Refresh is disabled.
- R2: With `strap_ddr2`=1 the commands are offered in this order as (cmd_ctrl, cmd_data): (0x08,0), (0x10,0), (0x20,0), (0x02,0), (0x01,0x100), (0x08,0), (0x04,0), (0x04,0), (0x01,0xA33), (0x02,0x382), (0x02,0x402). The cmd_ctrl bits are: bit0 base mode register load, bit1 extended mode register load, bit2 auto-refresh, bit3 precharge-all, bit4 second extended register load, bit5 third extended register load. Exactly one bit is set while `cmd_valid` is high.
- R3: With `strap_ddr2`=0 the commands are (0x08,0), (0x01,0x133), (0x02,0x002), (0x08,0), (0x01,0x033).
- R4: In DDR2 mode `ddr2_cfg` reads 0xA59 by the first cycle in which `cmd_valid` is high. That word holds write latency 2 in bits 13:10, ODT enable in bit 9, tFAW 22 in bits 7:2 and enable in bit 0. In DDR1 mode it stays 0.
- R5: A command with `cmd_valid` high and `cmd_ready` low is held the next cycle, with `cmd_ctrl` and `cmd_data` unchanged.
- R6: After each accepted command that is not the last, `cmd_valid` is low for exactly GAP_CYC cycles (default 4), then the next command is offered.
- R7: The cycle after the last command is accepted, `init_done` is 1 and `refresh_word` is 0x4000 plus the count in bits 9:0: 390 (0x4186) when `strap_ref40`=0, and 624 (0x4270) when it is 1. `dqs_tap0`=0x08 and `dqs_tap1`=0x09. From then on `init_done` stays high and no command is offered.
- R8: A `start` pulse while a series is running, or after it has finished, is ignored: the series neither restarts nor repeats.
- R9: The straps are sampled only at the accepted `start`. Changing them mid-series changes neither the commands nor the refresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches the series from idle |
| strap_ddr2 | input | 1 | 1 selects the DDR2 series, 0 selects DDR1 |
| strap_ref40 | input | 1 | 1 selects the 40 MHz refresh count, 0 selects 25 MHz |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Downstream accepts the offered command |
| cmd_ctrl | output | 6 | One-hot command control word |
| cmd_data | output | 16 | Mode register value for load commands, 0 otherwise |
| ddr2_cfg | output | 16 | DDR2 configuration word |
| refresh_word | output | 16 | Refresh enable (bit 14) and count (bits 9:0) |
| dqs_tap0 | output | 8 | DQS lane 0 tap setting |
| dqs_tap1 | output | 8 | DQS lane 1 tap setting |
| init_done | output | 1 | Initialization complete |

## Verification
A wrong step index or a wrong captured mode strap shows at the very next accepted command, as a control word or mode value that does not match the expected series. A faulty gap counter shows as a wrong count of low-valid cycles at the first command boundary. A handshake fault shows in the same cycle, as `cmd_ctrl` or `cmd_data` changing while `cmd_ready` is held low. Faults in the end-of-series registers, or in the captured reference strap, show only in the cycle after the last acceptance, as a wrong `refresh_word`, wrong tap values or a late `init_done`. The bench therefore checks these outputs exactly at that cycle.

// File: rtl/ddr_init_pkg.sv
// Package: shared command encoding, sequencer states and series lengths.
// Assumes a six-bit one-hot control word whose bit positions are fixed
// by the memory controller that decodes it.
package ddr_init_pkg;
    localparam int CMD_W   = 6;
    localparam int OP_MRS  = 0;
    localparam int OP_EMRS = 1;
    localparam int OP_AREF = 2;
    localparam int OP_PREA = 3;
    localparam int OP_EMR2 = 4;
    localparam int OP_EMR3 = 5;

    localparam int DDR2_STEPS = 11;
    localparam int DDR1_STEPS = 5;
    localparam int MAX_STEPS  = (DDR2_STEPS > DDR1_STEPS) ? DDR2_STEPS : DDR1_STEPS;
    localparam int STEP_W     = $clog2(MAX_STEPS);

    typedef logic [CMD_W-1:0] cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    // Return a control word with only the given bit set.
    function automatic cmd_t op_bit(input int pos);
        op_bit = cmd_t'(1) << pos;
    endfunction
endpackage

// File: rtl/ddr_init_rom.sv
// Step table: maps (series select, step index) to the command control word,
// the mode register value and a last-step flag. Purely combinational.
// Assumes step stays below the length of the selected series.
module ddr_init_rom
    import ddr_init_pkg::*;
#(
    parameter int MR_W          = 16,
    parameter int EMR2_VAL      = 'h000,
    parameter int EMR3_VAL      = 'h000,
    parameter int D2_EMR_INIT   = 'h000,
    parameter int D2_MR_DLLRST  = 'h100,
    parameter int D2_MR_NORMAL  = 'hA33,
    parameter int D2_EMR_OCDDEF = 'h382,
    parameter int D2_EMR_OCDEX  = 'h402,
    parameter int D1_MR_DLLRST  = 'h133,
    parameter int D1_EMR        = 'h002,
    parameter int D1_MR_NORMAL  = 'h033
) (
    input  logic              is_ddr2,
    input  logic [STEP_W-1:0] step,
    output cmd_t              ctrl,
    output logic [MR_W-1:0]   data,
    output logic              last
);
    // Decode the current step of the selected series.
    always_comb begin
        ctrl = '0;
        data = '0;
        last = 1'b0;
        if (is_ddr2) begin
            case (int'(step))
                0:  ctrl = op_bit(OP_PREA);
                1:  begin ctrl = op_bit(OP_EMR2); data = MR_W'(EMR2_VAL); end
                2:  begin ctrl = op_bit(OP_EMR3); data = MR_W'(EMR3_VAL); end
                3:  begin ctrl = op_bit(OP_EMRS); data = MR_W'(D2_EMR_INIT); end
                4:  begin ctrl = op_bit(OP_MRS);  data = MR_W'(D2_MR_DLLRST); end
                5:  ctrl = op_bit(OP_PREA);
                6:  ctrl = op_bit(OP_AREF);
                7:  ctrl = op_bit(OP_AREF);
                8:  begin ctrl = op_bit(OP_MRS);  data = MR_W'(D2_MR_NORMAL); end
                9:  begin ctrl = op_bit(OP_EMRS); data = MR_W'(D2_EMR_OCDDEF); end
                default: begin
                    ctrl = op_bit(OP_EMRS);
                    data = MR_W'(D2_EMR_OCDEX);
                    last = 1'b1;
                end
            endcase
        end else begin
            case (int'(step))
                0:  ctrl = op_bit(OP_PREA);
                1:  begin ctrl = op_bit(OP_MRS);  data = MR_W'(D1_MR_DLLRST); end
                2:  begin ctrl = op_bit(OP_EMRS); data = MR_W'(D1_EMR); end
                3:  ctrl = op_bit(OP_PREA);
                default: begin
                    ctrl = op_bit(OP_MRS);
                    data = MR_W'(D1_MR_NORMAL);
                    last = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ddr_init_gap.sv
// Inter-command gap timer. A load starts a window of GAP_CYC cycles, and
// expire is high in the last cycle of that window.
// Assumes GAP_CYC >= 1 and that load is not raised while a window runs.
module ddr_init_gap #(
    parameter int GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CNT_W = $clog2(GAP_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count the window down from GAP_CYC to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(GAP_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/ddr_init_fsm.sv
// Sequencer control: captures the straps at start, walks the step index,
// drives the handshake and loads the end-of-series registers.
// Assumes the step table reports last on the final step of each series.
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int CFG_W      = 16,
    parameter int CFG2_VAL   = 'hA59,
    parameter int REF_W      = 16,
    parameter int REF_EN_BIT = 14,
    parameter int REF_CNT_W  = 10,
    parameter int REF_CNT_25 = 390,
    parameter int REF_CNT_40 = 624,
    parameter int TAP_W      = 8,
    parameter int TAP0_INIT  = 'h08,
    parameter int TAP1_INIT  = 'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              strap_ddr2,
    input  logic              strap_ref40,
    input  logic              cmd_ready,
    input  logic              rom_last,
    input  logic              gap_expire,
    output logic              cmd_valid,
    output logic              gap_load,
    output logic              mode_ddr2,
    output logic [STEP_W-1:0] step,
    output logic [CFG_W-1:0]  ddr2_cfg,
    output logic [REF_W-1:0]  refresh_word,
    output logic [TAP_W-1:0]  dqs_tap0,
    output logic [TAP_W-1:0]  dqs_tap1,
    output logic              init_done
);
    localparam int CNT_MASK = (1 << REF_CNT_W) - 1;
    localparam logic [REF_W-1:0] REF_WORD_25 =
        REF_W'((1 << REF_EN_BIT) | (REF_CNT_25 & CNT_MASK));
    localparam logic [REF_W-1:0] REF_WORD_40 =
        REF_W'((1 << REF_EN_BIT) | (REF_CNT_40 & CNT_MASK));

    seq_state_t state;
    logic       ref40_q;
    logic       accept;

    assign accept   = (state == ST_ISSUE) && cmd_ready;
    assign gap_load = accept && !rom_last;

    // Main sequencer: idle, offer, gap, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cmd_valid    <= 1'b0;
            mode_ddr2    <= 1'b0;
            ref40_q      <= 1'b0;
            step         <= '0;
            ddr2_cfg     <= '0;
            refresh_word <= '0;
            dqs_tap0     <= '0;
            dqs_tap1     <= '0;
            init_done    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_ddr2 <= strap_ddr2;
                        ref40_q   <= strap_ref40;
                        ddr2_cfg  <= strap_ddr2 ? CFG_W'(CFG2_VAL) : '0;
                        step      <= '0;
                        cmd_valid <= 1'b1;
                        state     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        cmd_valid <= 1'b0;
                        if (rom_last) begin
                            refresh_word <= ref40_q ? REF_WORD_40 : REF_WORD_25;
                            dqs_tap0     <= TAP_W'(TAP0_INIT);
                            dqs_tap1     <= TAP_W'(TAP1_INIT);
                            init_done    <= 1'b1;
                            state        <= ST_DONE;
                        end else begin
                            step  <= step + STEP_W'(1);
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expire) begin
                        cmd_valid <= 1'b1;
                        state     <= ST_ISSUE;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_init_seq.sv
// Top level of the DDR initialization sequencer: joins the control FSM,
// the step table and the gap timer, and gates the command outputs with valid.
// Assumes GAP_CYC >= 1 and mode values that fit in MR_W bits.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int GAP_CYC       = 4,
    parameter int MR_W          = 16,
    parameter int EMR2_VAL      = 'h000,
    parameter int EMR3_VAL      = 'h000,
    parameter int D2_EMR_INIT   = 'h000,
    parameter int D2_MR_DLLRST  = 'h100,
    parameter int D2_MR_NORMAL  = 'hA33,
    parameter int D2_EMR_OCDDEF = 'h382,
    parameter int D2_EMR_OCDEX  = 'h402,
    parameter int D1_MR_DLLRST  = 'h133,
    parameter int D1_EMR        = 'h002,
    parameter int D1_MR_NORMAL  = 'h033,
    parameter int CFG_W         = 16,
    parameter int D2_WLAT       = 2,
    parameter int D2_ODT_EN     = 1,
    parameter int D2_TFAW       = 22,
    parameter int REF_W         = 16,
    parameter int REF_EN_BIT    = 14,
    parameter int REF_CNT_W     = 10,
    parameter int REF_CNT_25    = 390,
    parameter int REF_CNT_40    = 624,
    parameter int TAP_W         = 8,
    parameter int TAP0_INIT     = 'h08,
    parameter int TAP1_INIT     = 'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             strap_ddr2,
    input  logic             strap_ref40,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CMD_W-1:0] cmd_ctrl,
    output logic [MR_W-1:0]  cmd_data,
    output logic [CFG_W-1:0] ddr2_cfg,
    output logic [REF_W-1:0] refresh_word,
    output logic [TAP_W-1:0] dqs_tap0,
    output logic [TAP_W-1:0] dqs_tap1,
    output logic             init_done
);
    // DDR2 configuration word: latency 13:10, ODT 9, tFAW 7:2, enable 0.
    localparam int CFG2_VAL = ((D2_WLAT & 'hF) << 10) | ((D2_ODT_EN & 1) << 9) |
                              ((D2_TFAW & 'h3F) << 2) | 1;

    logic              mode_ddr2;
    logic [STEP_W-1:0] step;
    cmd_t              rom_ctrl;
    logic [MR_W-1:0]   rom_data;
    logic              rom_last;
    logic              gap_load;
    logic              gap_expire;

    ddr_init_fsm #(
        .CFG_W(CFG_W), .CFG2_VAL(CFG2_VAL), .REF_W(REF_W),
        .REF_EN_BIT(REF_EN_BIT), .REF_CNT_W(REF_CNT_W),
        .REF_CNT_25(REF_CNT_25), .REF_CNT_40(REF_CNT_40),
        .TAP_W(TAP_W), .TAP0_INIT(TAP0_INIT), .TAP1_INIT(TAP1_INIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .strap_ddr2(strap_ddr2), .strap_ref40(strap_ref40),
        .cmd_ready(cmd_ready), .rom_last(rom_last), .gap_expire(gap_expire),
        .cmd_valid(cmd_valid), .gap_load(gap_load), .mode_ddr2(mode_ddr2),
        .step(step), .ddr2_cfg(ddr2_cfg), .refresh_word(refresh_word),
        .dqs_tap0(dqs_tap0), .dqs_tap1(dqs_tap1), .init_done(init_done)
    );

    ddr_init_rom #(
        .MR_W(MR_W), .EMR2_VAL(EMR2_VAL), .EMR3_VAL(EMR3_VAL),
        .D2_EMR_INIT(D2_EMR_INIT), .D2_MR_DLLRST(D2_MR_DLLRST),
        .D2_MR_NORMAL(D2_MR_NORMAL), .D2_EMR_OCDDEF(D2_EMR_OCDDEF),
        .D2_EMR_OCDEX(D2_EMR_OCDEX), .D1_MR_DLLRST(D1_MR_DLLRST),
        .D1_EMR(D1_EMR), .D1_MR_NORMAL(D1_MR_NORMAL)
    ) u_rom (
        .is_ddr2(mode_ddr2), .step(step),
        .ctrl(rom_ctrl), .data(rom_data), .last(rom_last)
    );

    ddr_init_gap #(
        .GAP_CYC(GAP_CYC)
    ) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .expire(gap_expire)
    );

    // Drive the command fields only while a command is offered.
    always_comb begin
        cmd_ctrl = cmd_valid ? rom_ctrl : '0;
        cmd_data = cmd_valid ? rom_data : '0;
    end
endmodule

// File: rtl/ddr_init_chk.sv
// Checker for the sequencer's port behaviour: handshake hold, one-hot
// commands, inter-command gap length and end-of-series state.
// Assumes GAP_CYC below 65535.
module ddr_init_chk #(
    parameter int GAP_CYC = 4,
    parameter int CMD_W   = 6,
    parameter int MR_W    = 16,
    parameter int REF_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CMD_W-1:0] cmd_ctrl,
    input logic [MR_W-1:0]  cmd_data,
    input logic [REF_W-1:0] refresh_word,
    input logic             init_done
);
    logic [15:0] low_cnt;
    logic        armed;

    // Count low-valid cycles since the most recent acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            armed   <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            low_cnt <= '0;
            armed   <= 1'b1;
        end else if (!cmd_valid && armed && low_cnt != 16'hFFFF) begin
            low_cnt <= low_cnt + 16'd1;
        end
    end

    a_r5_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_ctrl) && $stable(cmd_data)));

    a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_ctrl) == 1));

    a_r6_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_valid) && armed) |-> (low_cnt == 16'(GAP_CYC)));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && !cmd_valid));

    a_r7_refresh_on: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> refresh_word[14]);

    a_r1_refresh_off: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (refresh_word == '0));
endmodule

bind ddr_init_seq ddr_init_chk #(
    .GAP_CYC(GAP_CYC), .CMD_W(ddr_init_pkg::CMD_W), .MR_W(MR_W), .REF_W(REF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ctrl(cmd_ctrl), .cmd_data(cmd_data), .refresh_word(refresh_word),
    .init_done(init_done)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        strap_ddr2 = 1'b0;
    logic        strap_ref40 = 1'b0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid;
    logic [5:0]  cmd_ctrl;
    logic [15:0] cmd_data;
    logic [15:0] ddr2_cfg;
    logic [15:0] refresh_word;
    logic [7:0]  dqs_tap0;
    logic [7:0]  dqs_tap1;
    logic        init_done;

    int checks = 0;
    int failures = 0;

    ddr_init_seq #(.GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .strap_ddr2(strap_ddr2),
        .strap_ref40(strap_ref40), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_ctrl(cmd_ctrl), .cmd_data(cmd_data), .ddr2_cfg(ddr2_cfg),
        .refresh_word(refresh_word), .dqs_tap0(dqs_tap0), .dqs_tap1(dqs_tap1),
        .init_done(init_done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected command series, written out from the requirements.
    function automatic void exp_cmd(input bit d2, input int i, output int c, output int d);
        int c2[11] = '{8, 16, 32, 2, 1, 8, 4, 4, 1, 2, 2};
        int d2v[11] = '{0, 0, 0, 0, 'h100, 0, 0, 0, 'hA33, 'h382, 'h402};
        int c1[5] = '{8, 1, 2, 8, 1};
        int d1v[5] = '{0, 'h133, 'h002, 0, 'h033};
        if (d2) begin c = c2[i]; d = d2v[i]; end
        else    begin c = c1[i]; d = d1v[i]; end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; cmd_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_flow(input bit d2, input bit r40, input bit stall, input bit disturb);
        int n_exp = d2 ? 11 : 5;
        int got = 0;
        int gap = 0;
        bit pend = 1'b0;
        int cyc = 0;
        int ec, ed;
        do_reset();
        strap_ddr2 = d2; strap_ref40 = r40;
        chk("R1 cfg idle", int'(ddr2_cfg), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R4 cfg at first offer", int'(ddr2_cfg), d2 ? 'hA59 : 0);
        chk("R2 first valid", int'(cmd_valid), 1);
        while (got < n_exp && cyc < 2000) begin
            if (disturb && (cyc == 3 || cyc == 20)) begin
                start = 1'b1; strap_ddr2 = ~d2; strap_ref40 = ~r40;  // R8 R9
            end else begin
                start = 1'b0;
            end
            cmd_ready = stall ? (cyc % 3 == 2) : 1'b1;
            if (cmd_valid) begin
                if (pend) begin
                    chk("R6 gap length", gap, GAP);
                    pend = 1'b0;
                end
                if (cmd_ready) begin
                    exp_cmd(d2, got, ec, ed);
                    chk(d2 ? "R2 ctrl" : "R3 ctrl", int'(cmd_ctrl), ec);
                    chk(d2 ? "R2 data" : "R3 data", int'(cmd_data), ed);
                    chk("R7 done low in series", int'(init_done), 0);
                    got++;
                    pend = 1'b1;
                    gap = 0;
                end
            end else if (pend) begin
                gap++;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_ready = 1'b0;
        start = 1'b0;
        chk("R2 R3 command count", got, n_exp);
        chk("R7 done next cycle", int'(init_done), 1);
        chk("R7 refresh word", int'(refresh_word), r40 ? 'h4270 : 'h4186);
        chk("R7 tap0", int'(dqs_tap0), 'h08);
        chk("R7 tap1", int'(dqs_tap1), 'h09);
        chk("R4 cfg kept", int'(ddr2_cfg), d2 ? 'hA59 : 0);
        // R8: start after completion is ignored.
        start = 1'b1;
        cmd_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk("R8 no offer after done", int'(cmd_valid), 0);
            @(negedge clk);
        end
        chk("R7 done held", int'(init_done), 1);
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 valid", int'(cmd_valid), 0);
        chk("R1 done", int'(init_done), 0);
        chk("R1 refresh off", int'(refresh_word), 0);
        chk("R1 taps", int'({dqs_tap0, dqs_tap1}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle without start", int'(cmd_valid), 0);
    endtask

    task automatic t_ddr2_25_fast();  run_flow(1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_ddr2_40_stall(); run_flow(1'b1, 1'b1, 1'b1, 1'b0); endtask
    task automatic t_ddr1_25_stall(); run_flow(1'b0, 1'b0, 1'b1, 1'b0); endtask
    task automatic t_ddr1_40_disturb(); run_flow(1'b0, 1'b1, 1'b0, 1'b1); endtask
    task automatic t_ddr2_25_disturb(); run_flow(1'b1, 1'b0, 1'b1, 1'b1); endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_ddr2_25_fast();
        t_ddr2_40_stall();
        t_ddr1_25_stall();
        t_ddr1_40_disturb();
        t_ddr2_25_disturb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule